// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block decides, for each received frame, whether its 48-bit destination address is kept or dropped. A receive front end presents the address together with a one-cycle strobe. Exactly one clock later the block returns a decision pulse that carries an accept flag. The decision combines two sources. The first is a set of per-class accept flags for unicast, multicast and broadcast. The second is a comparison against a small table of programmable station addresses.

Software configures the filter through a simple write port. A command word selects the class flags. It also switches table comparison on and can invert the table result so that listed stations are rejected instead of accepted. An enable mask picks which table entries take part in the comparison. Each 48-bit entry is written as two 32-bit words. The high word is staged, and the low-word write commits the whole entry at once, so a comparison never sees half of an updated address.

Top module: `dst_addr_filter`

## Requirements
- R1: After reset `dec_valid` and `dec_accept` are 0. Each cycle with `da_valid` high yields exactly one cycle of `dec_valid` high on the next clock. No other cycle raises `dec_valid`.
- R2: The write map is as follows. Address 0 is the command word and address 1 is the enable mask. Address 2+2i is the high word of entry i and address 3+2i is its low word. The high word holds address bytes 0..3 with byte 0 in bits 31:24. The low word holds bytes 4 and 5 in bits 31:16, and its bits 15:0 are ignored. Byte 0 is `da[47:40]`.
- R3: Bit i of the enable mask includes entry i in the comparison. An entry whose bit is 0 never counts as a match.
- R4: Command bit 0 accepts every unicast address, meaning bit 0 of byte 0 is 0.
- R5: Command bit 1 accepts every multicast address, meaning bit 0 of byte 0 is 1 and the address is not all ones.
- R6: Command bit 2 accepts the broadcast address, which is all ones. Broadcast is not accepted by command bit 1.
- R7: With command bit 4 set, command bit 3 at 0 accepts addresses that match an enabled entry. Command bit 3 at 1 accepts addresses that match no enabled entry and rejects matching ones.
- R8: With command bit 4 clear, the table has no effect and only the class flags decide.
- R9: A high-word write alone does not change the address an entry matches. The entry takes the staged high word and the new low word together on the low-word write.
- R10: A configuration write in the same cycle as a strobe does not affect that strobe's decision. It does apply to every later strobe.
- R11: `dec_accept` is 0 in every cycle in which `dec_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| da_valid | input | 1 | Destination address strobe |
| da | input | 48 | Destination address, byte 0 in bits 47:40 |
| dec_valid | output | 1 | Decision valid, one clock after the strobe |
| dec_accept | output | 1 | Accept flag of the decision |

## Verification
The assertions assume that `da` is stable and defined in every strobe cycle. They also assume that `cfg_addr` is defined whenever `cfg_we` is high, and that writes to unmapped addresses do nothing. The stimulus drives all inputs on the falling edge from known values. It draws addresses from a pool built from the programmed entries, near misses with one byte flipped, broadcast, and random unicast and multicast values. This pool makes table hits, misses and each address class frequent. Configuration writes are interleaved with strobes at random, and some of them land in the same cycle as a strobe.

// File: rtl/daf_pkg.sv
package daf_pkg;
  localparam int MAC_W    = 48;
  localparam int WORD_W   = 32;
  localparam int CMD_W    = 5;
  localparam int CMD_UNI  = 0;
  localparam int CMD_MC   = 1;
  localparam int CMD_BC   = 2;
  localparam int CMD_INV  = 3;
  localparam int CMD_CMP  = 4;
  typedef logic [MAC_W-1:0] mac_t;
endpackage

// File: rtl/daf_rst_sync.sv
module daf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ni
);
  logic [1:0] sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_ni = sync_q[1];
endmodule

// File: rtl/daf_cfg_regs.sv
module daf_cfg_regs
  import daf_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 4
) (
  input  logic                     clk,
  input  logic                     rst_ni,
  input  logic                     we,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [WORD_W-1:0]        wdata,
  output logic [CMD_W-1:0]         cmd,
  output logic [ENTRIES-1:0]       en,
  output logic [ENTRIES*MAC_W-1:0] tbl
);
  localparam int LO_W = MAC_W - WORD_W;

  logic [CMD_W-1:0]   cmd_q, cmd_d;
  logic [ENTRIES-1:0] en_q, en_d;

  always_comb begin
    cmd_d = cmd_q;
    en_d  = en_q;
    if (we && addr == ADDR_W'(0)) cmd_d = wdata[CMD_W-1:0];
    if (we && addr == ADDR_W'(1)) en_d  = wdata[ENTRIES-1:0];
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= '0;
      en_q  <= '0;
    end else begin
      cmd_q <= cmd_d;
      en_q  <= en_d;
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic              hi_sel, lo_sel;
    logic [WORD_W-1:0] stage_q, stage_d;
    logic [MAC_W-1:0]  ent_q, ent_d;

    assign hi_sel = we && (addr == ADDR_W'(2 + 2*g));
    assign lo_sel = we && (addr == ADDR_W'(3 + 2*g));

    always_comb begin
      stage_d = hi_sel ? wdata : stage_q;
      ent_d   = lo_sel ? {stage_q, wdata[WORD_W-1 -: LO_W]} : ent_q;
    end

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) begin
        stage_q <= '0;
        ent_q   <= '0;
      end else begin
        stage_q <= stage_d;
        ent_q   <= ent_d;
      end
    end

    assign tbl[g*MAC_W +: MAC_W] = ent_q;
  end

  assign cmd = cmd_q;
  assign en  = en_q;
endmodule

// File: rtl/daf_match.sv
module daf_match
  import daf_pkg::*;
#(
  parameter int ENTRIES = 4
) (
  input  mac_t                     da,
  input  logic [ENTRIES-1:0]       en,
  input  logic [ENTRIES*MAC_W-1:0] tbl,
  output logic                     hit
);
  logic [ENTRIES-1:0] eq;
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign eq[g] = en[g] && (tbl[g*MAC_W +: MAC_W] == da);
  end
  assign hit = |eq;
endmodule

// File: rtl/daf_decide.sv
module daf_decide
  import daf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             strobe,
  input  mac_t             da,
  input  logic             hit,
  input  logic [CMD_W-1:0] cmd,
  output logic             dec_valid,
  output logic             dec_accept
);
  localparam int GRP_BIT = MAC_W - 8;

  logic is_bc, is_mc, is_uc, class_ok, table_ok;
  logic valid_q, valid_d, acc_q, acc_d;

  always_comb begin
    is_bc    = &da;
    is_mc    = da[GRP_BIT] && !is_bc;
    is_uc    = !da[GRP_BIT];
    class_ok = (cmd[CMD_UNI] && is_uc) || (cmd[CMD_MC] && is_mc) ||
               (cmd[CMD_BC] && is_bc);
    table_ok = cmd[CMD_CMP] && (hit ^ cmd[CMD_INV]);
    valid_d  = strobe;
    acc_d    = strobe && (class_ok || table_ok);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      acc_q   <= 1'b0;
    end else begin
      valid_q <= valid_d;
      acc_q   <= acc_d;
    end
  end

  assign dec_valid  = valid_q;
  assign dec_accept = acc_q;
endmodule

// File: rtl/dst_addr_filter.sv
module dst_addr_filter
  import daf_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = $clog2(2*ENTRIES + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              da_valid,
  input  logic [47:0]       da,
  output logic              dec_valid,
  output logic              dec_accept
);
  logic                     rst_ni;
  logic [CMD_W-1:0]         cmd;
  logic [ENTRIES-1:0]       en;
  logic [ENTRIES*MAC_W-1:0] tbl;
  logic                     hit;

  daf_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_ni(rst_ni));

  daf_cfg_regs #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_ni(rst_ni), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .cmd(cmd), .en(en), .tbl(tbl)
  );

  daf_match #(.ENTRIES(ENTRIES)) u_match (
    .da(da), .en(en), .tbl(tbl), .hit(hit)
  );

  daf_decide u_dec (
    .clk(clk), .rst_ni(rst_ni), .strobe(da_valid), .da(da), .hit(hit),
    .cmd(cmd), .dec_valid(dec_valid), .dec_accept(dec_accept)
  );
endmodule

// File: rtl/daf_checker.sv
module daf_checker
  import daf_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 4
) (
  input logic                     clk,
  input logic                     rst_ni,
  input logic                     cfg_we,
  input logic [ADDR_W-1:0]        cfg_addr,
  input logic                     da_valid,
  input logic [47:0]              da,
  input logic [CMD_W-1:0]         cmd,
  input logic [ENTRIES*MAC_W-1:0] tbl,
  input logic                     hit,
  input logic                     dec_valid,
  input logic                     dec_accept
);
  logic hi_wr;
  always_comb begin
    hi_wr = 1'b0;
    for (int i = 0; i < ENTRIES; i++)
      if (cfg_we && cfg_addr == ADDR_W'(2 + 2*i)) hi_wr = 1'b1;
  end

  AST_STROBE_TO_DEC: assert property (@(posedge clk) disable iff (!rst_ni)
    da_valid |=> dec_valid); // R1
  AST_NO_SPURIOUS_DEC: assert property (@(posedge clk) disable iff (!rst_ni)
    !da_valid |=> !dec_valid); // R1
  AST_BCAST_FLAG: assert property (@(posedge clk) disable iff (!rst_ni)
    (da_valid && (&da) && cmd[CMD_BC]) |=> dec_accept); // R6
  AST_TABLE_HIT: assert property (@(posedge clk) disable iff (!rst_ni)
    (da_valid && hit && cmd[CMD_CMP] && !cmd[CMD_INV]) |=> dec_accept); // R7
  AST_INVERT_HIT: assert property (@(posedge clk) disable iff (!rst_ni)
    (da_valid && hit && cmd == 5'b11000) |=> !dec_accept); // R7
  AST_CMP_OFF: assert property (@(posedge clk) disable iff (!rst_ni)
    (da_valid && cmd == 5'b00000) |=> !dec_accept); // R8
  AST_HI_STAGED: assert property (@(posedge clk) disable iff (!rst_ni)
    hi_wr |=> $stable(tbl)); // R9
  AST_IDLE_REJECT: assert property (@(posedge clk) disable iff (!rst_ni)
    !dec_valid |-> !dec_accept); // R11
endmodule

bind dst_addr_filter daf_checker #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_ni(rst_ni), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .da_valid(da_valid), .da(da), .cmd(cmd), .tbl(tbl), .hit(hit),
  .dec_valid(dec_valid), .dec_accept(dec_accept)
);

// File: tb/dst_addr_filter_test.sv
`timescale 1ns/1ps
module dst_addr_filter_test;
  localparam int N  = 4;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [31:0]   cfg_wdata = '0;
  logic          da_valid = 1'b0;
  logic [47:0]   da = '0;
  logic          dec_valid, dec_accept;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [47:0] m_ent [N];
  logic [31:0] m_stage [N];
  logic [N-1:0] m_en = '0;
  logic [4:0]   m_cmd = '0;

  always #2.5 clk = ~clk;

  dst_addr_filter #(.ENTRIES(N)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .da_valid(da_valid), .da(da),
    .dec_valid(dec_valid), .dec_accept(dec_accept)
  );

  function automatic bit ref_acc(input logic [47:0] a);
    bit bc, mc, uc, h;
    bc = &a;
    mc = a[40] && !bc;
    uc = !a[40];
    h  = 0;
    for (int i = 0; i < N; i++) if (m_en[i] && m_ent[i] == a) h = 1;
    return (m_cmd[0] && uc) || (m_cmd[1] && mc) || (m_cmd[2] && bc) ||
           (m_cmd[4] && (h ^ m_cmd[3]));
  endfunction

  function automatic void model_wr(input int ad, input logic [31:0] d);
    if (ad == 0) m_cmd = d[4:0];
    else if (ad == 1) m_en = d[N-1:0];
    else if (ad < 2 + 2*N) begin
      if (ad % 2 == 0) m_stage[(ad-2)/2] = d;
      else m_ent[(ad-3)/2] = {m_stage[(ad-3)/2], d[31:16]};
    end
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input int ad, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = AW'(ad); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    model_wr(ad, d);
  endtask

  task automatic set_ent(input int i, input logic [47:0] a);
    wr(2 + 2*i, a[47:16]);
    wr(3 + 2*i, {a[15:0], 16'hA5C3});
  endtask

  task automatic probe(input string req, input logic [47:0] a);
    bit e;
    @(negedge clk);
    da = a; da_valid = 1;
    e = ref_acc(a);
    @(negedge clk);
    da_valid = 0;
    chk("R1", dec_valid, 1'b1);
    chk(req, dec_accept, e);
    @(negedge clk);
    chk("R1", dec_valid, 1'b0);
    chk("R11", dec_accept, 1'b0);
  endtask

  localparam logic [47:0] A  = 48'h0011_2233_4455;
  localparam logic [47:0] B  = 48'h0266_7788_99AA;
  localparam logic [47:0] BC = 48'hFFFF_FFFF_FFFF;
  localparam logic [47:0] MC = 48'h0100_5E00_0001;
  localparam logic [47:0] UC = 48'h00AB_CDEF_0123;

  initial begin
    for (int i = 0; i < N; i++) begin m_ent[i] = '0; m_stage[i] = '0; end
    #1;
    chk("R1", dec_valid, 1'b0);
    chk("R11", dec_accept, 1'b0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1", dec_valid, 1'b0);

    // R2 packing: low word bits 15:0 are ignored
    set_ent(0, A);
    wr(1, 32'h1);
    wr(0, 32'h10);
    probe("R2", A);
    probe("R2", A ^ 48'h0000_0000_0100);
    probe("R2", A ^ 48'h0100_0000_0000);
    // R3 enable mask
    wr(1, 32'h0);
    probe("R3", A);
    wr(1, 32'h2);
    probe("R3", A);
    wr(1, 32'h1);
    // R7 inversion
    wr(0, 32'h18);
    probe("R7", A);
    probe("R7", UC);
    // R4 unicast flag
    wr(0, 32'h01);
    probe("R4", UC);
    probe("R4", MC);
    // R5 multicast flag, broadcast excluded
    wr(0, 32'h02);
    probe("R5", MC);
    probe("R6", BC);
    probe("R5", UC);
    // R6 broadcast flag
    wr(0, 32'h04);
    probe("R6", BC);
    probe("R6", MC);
    // R8 compare off: table hit is ignored
    wr(0, 32'h00);
    probe("R8", A);
    wr(0, 32'h10);
    // R9 staged high word
    wr(2, B[47:16]);
    probe("R9", A);
    probe("R9", B);
    wr(3, {B[15:0], 16'h0});
    probe("R9", B);
    probe("R9", A);
    // R10 write coinciding with strobe
    begin
      bit e;
      wr(2, A[47:16]);
      @(negedge clk);
      cfg_we = 1; cfg_addr = AW'(3); cfg_wdata = {A[15:0], 16'h0};
      da = A; da_valid = 1;
      e = ref_acc(A);
      @(negedge clk);
      cfg_we = 0; da_valid = 0;
      model_wr(3, {A[15:0], 16'h0});
      chk("R10", dec_accept, e);
      chk("R10", dec_valid, 1'b1);
      probe("R10", A);
    end

    // random mix
    void'($urandom(32'd2024));
    for (int it = 0; it < 600; it++) begin
      int k;
      k = $urandom_range(0, 9);
      if (k == 0) wr(0, $urandom_range(0, 31));
      else if (k == 1) wr(1, $urandom_range(0, 15));
      else if (k == 2) begin
        int e;
        logic [47:0] a;
        e = $urandom_range(0, N-1);
        a = {$urandom(), $urandom()} & 48'hFEFF_FFFF_FFFF;
        if ($urandom_range(0, 1) == 1) a[40] = 1'b1;
        set_ent(e, a);
      end else if (k == 3) begin
        int e;
        logic [47:0] cur;
        bit ex;
        e = $urandom_range(0, N-1);
        cur = m_ent[$urandom_range(0, N-1)];
        @(negedge clk);
        cfg_we = 1; cfg_addr = AW'(3 + 2*e); cfg_wdata = $urandom();
        da = cur; da_valid = 1;
        ex = ref_acc(cur);
        @(negedge clk);
        model_wr(3 + 2*e, cfg_wdata);
        cfg_we = 0; da_valid = 0;
        chk("R10", dec_accept, ex);
      end else begin
        int p;
        logic [47:0] a;
        p = $urandom_range(0, 5);
        case (p)
          0: a = m_ent[$urandom_range(0, N-1)];
          1: a = m_ent[$urandom_range(0, N-1)] ^ (48'hFF << (8*$urandom_range(0, 5)));
          2: a = BC;
          3: a = {$urandom(), $urandom()} | 48'h0100_0000_0000;
          default: a = {$urandom(), $urandom()} & 48'hFEFF_FFFF_FFFF;
        endcase
        probe(p < 2 ? "R7" : (p == 2 ? "R6" : (p == 3 ? "R5" : "R4")), a);
      end
    end

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(5ns * 100000);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule